// File: doc/BRIEF.md
# Free-Entry Tracker with Full Detection

This block keeps one occupancy bit for each 72-bit entry of a small search array and from it maintains the address a learn operation will fill next. An entry is empty when its occupancy bit is 0 and occupied when it is 1. Each quadrant of the array is set to either single-width entries or double-width entries. A double-width entry is an aligned even/odd pair of 72-bit slots. Whenever a write or a learn lands, the block reloads its free-address register with the lowest location that can take a new entry. It also reloads a local full flag, which is set when no such location exists.

A small bank of comparand registers, organised as even/odd pairs, holds keys captured earlier by search cycles. A learn request picks one pair and emits that pair at the current free address, then marks that location occupied. A device-level full output combines the local flag with full indications from neighbouring devices. Full-in inputs that are marked unused by a parameter are ignored.

Top module: `nfa_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, every entry reads as empty, free_addr is 0, and local_full, dev_full, pair_err and learn_we are all 0.
- R2: A write stores wr_occ as the occupancy bit of entry wr_addr. On the clock edge that takes a write or a learn, free_addr is loaded with the lowest free location as seen after that operation. The new value is visible from the following cycle. Without a write or a learn, free_addr and local_full hold their values.
- R3: In a quadrant with quad_wide[q]=1 (entries q*QUAD_DEPTH to q*QUAD_DEPTH+QUAD_DEPTH-1), a location is free only when both occupancy bits of an even/odd pair are 0. The free address found there is the even one, so its bit 0 is 0.
- R4: A write into a wide quadrant that leaves the two bits of its pair different sets pair_err, which stays 1 until reset. Such a pair counts as occupied.
- R5: local_full is loaded with 1 when no free location exists after a write or learn. In that case free_addr keeps its previous value.
- R6: dev_full is local_full ANDed with every full_in bit whose FULL_IN_USED bit is 1. Full_in bits with a 0 in FULL_IN_USED have no effect.
- R7: cmp_we stores cmp_data into comparand register 2*cmp_pair when cmp_half=0 (cycle A, even) and into 2*cmp_pair+1 when cmp_half=1 (cycle B, odd).
- R8: A learn request accepted in a cycle makes learn_we 1 in the next cycle. In that cycle learn_addr equals the free_addr of the request cycle, learn_lo holds register 2*learn_pair and learn_hi holds register 2*learn_pair+1. The target entry is marked occupied, and in a wide quadrant its partner is marked too.
- R9: A learn request is ignored when local_full is 1 or when wr_valid is 1 in the same cycle. When ignored, learn_we stays 0 and no occupancy bit is set by the learn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_wide | input | NUM_QUAD | Per-quadrant width: 1 means paired double-width entries |
| wr_valid | input | 1 | Entry write strobe |
| wr_addr | input | AW | 72-bit entry address of the write |
| wr_occ | input | 1 | New occupancy bit for the written entry |
| cmp_we | input | 1 | Comparand register write strobe |
| cmp_half | input | 1 | 0 selects the even (cycle A) register, 1 the odd (cycle B) register |
| cmp_pair | input | PW | Comparand pair index |
| cmp_data | input | CMP_W | Comparand value to store |
| learn_req | input | 1 | Learn request |
| learn_pair | input | PW | Comparand pair used by the learn |
| full_in | input | FULL_IN_N | Full indications from other devices |
| free_addr | output | FREE_W | Next free 72-bit address, upper bits zero |
| local_full | output | 1 | No free location in this array |
| dev_full | output | 1 | Combined full indication |
| pair_err | output | 1 | Sticky mismatched-pair flag |
| learn_we | output | 1 | Learn write strobe |
| learn_addr | output | FREE_W | Address of the learn write |
| learn_lo | output | CMP_W | Even comparand register of the learn |
| learn_hi | output | CMP_W | Odd comparand register of the learn |

## Verification
The bench fills the array completely, then frees single slots and half pairs. A design that searched the state before the write, instead of after it, would point at an entry that was just filled. A design that accepted odd slots in wide quadrants would produce an odd free address. A design that read a mismatched pair as free, or that let pair_err clear, is caught by writing one half of a pair. The bench also sends learns while the array is full and learns together with a write. It checks that these create no write strobe and leave the occupancy unchanged. A design that ignored FULL_IN_USED would produce a wrong dev_full when random full_in values are applied.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  // Selects which register of a comparand pair a search cycle fills.
  typedef enum logic {
    HALF_EVEN = 1'b0,
    HALF_ODD  = 1'b1
  } cmp_half_e;

  // Address of the other slot of an aligned pair.
  function automatic logic [15:0] partner_of(input logic [15:0] a);
    return {a[15:1], ~a[0]};
  endfunction
endpackage

// File: rtl/nfa_occ_store.sv
module nfa_occ_store #(
  parameter int NUM_QUAD   = 4,
  parameter int QUAD_DEPTH = 8,
  localparam int N     = NUM_QUAD * QUAD_DEPTH,
  localparam int AW    = $clog2(N),
  localparam int QBITS = $clog2(QUAD_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_QUAD-1:0] quad_wide,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic                wr_occ,
  input  logic                lrn_en,
  input  logic [AW-1:0]       lrn_addr,
  output logic [N-1:0]        occ_d,
  output logic                err_q
);
  import nfa_pkg::*;

  logic [N-1:0] occ_q;
  logic         err_d;
  logic [AW-1:0] wr_mate;
  logic [AW-1:0] lrn_mate;
  logic          wr_wide;
  logic          lrn_wide;

  always_comb begin
    wr_mate  = AW'(partner_of(16'(wr_addr)));
    lrn_mate = AW'(partner_of(16'(lrn_addr)));
    wr_wide  = quad_wide[wr_addr[AW-1:QBITS]];
    lrn_wide = quad_wide[lrn_addr[AW-1:QBITS]];
    occ_d    = occ_q;
    if (wr_en) begin
      occ_d[wr_addr] = wr_occ;
    end else if (lrn_en) begin
      occ_d[lrn_addr] = 1'b1;
      if (lrn_wide) occ_d[lrn_mate] = 1'b1;
    end
    err_d = err_q;
    if (wr_en && wr_wide && (occ_d[wr_addr] != occ_d[wr_mate])) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en || lrn_en) occ_q <= occ_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/nfa_free_finder.sv
module nfa_free_finder #(
  parameter int NUM_QUAD   = 4,
  parameter int QUAD_DEPTH = 8,
  localparam int N  = NUM_QUAD * QUAD_DEPTH,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]        occ,
  input  logic [NUM_QUAD-1:0] quad_wide,
  output logic                found,
  output logic [AW-1:0]       idx
);
  logic [N-1:0] avail;

  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam int Q = i / QUAD_DEPTH;
    if (i % 2 == 0) begin : g_even
      assign avail[i] = quad_wide[Q] ? (~occ[i] & ~occ[i+1]) : ~occ[i];
    end else begin : g_odd
      assign avail[i] = ~quad_wide[Q] & ~occ[i];
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/nfa_cmp_bank.sv
module nfa_cmp_bank #(
  parameter int NUM_PAIRS = 4,
  parameter int CMP_W     = 8,
  localparam int PW = $clog2(NUM_PAIRS),
  localparam int NR = 2 * NUM_PAIRS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             half,
  input  logic [PW-1:0]    wr_pair,
  input  logic [CMP_W-1:0] wr_data,
  input  logic [PW-1:0]    rd_pair,
  output logic [CMP_W-1:0] rd_even,
  output logic [CMP_W-1:0] rd_odd
);
  import nfa_pkg::*;

  logic [CMP_W-1:0] regs_q [NR];
  logic [CMP_W-1:0] regs_d [NR];
  cmp_half_e        sel_half;

  always_comb begin
    sel_half = cmp_half_e'(half);
    for (int r = 0; r < NR; r++) regs_d[r] = regs_q[r];
    if (we) begin
      if (sel_half == HALF_ODD) regs_d[{wr_pair, 1'b1}] = wr_data;
      else                      regs_d[{wr_pair, 1'b0}] = wr_data;
    end
    rd_even = regs_q[{rd_pair, 1'b0}];
    rd_odd  = regs_q[{rd_pair, 1'b1}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) regs_q[r] <= '0;
    end else if (we) begin
      for (int r = 0; r < NR; r++) regs_q[r] <= regs_d[r];
    end
  end
endmodule

// File: rtl/nfa_tracker.sv
module nfa_tracker #(
  parameter int                 NUM_QUAD     = 4,
  parameter int                 QUAD_DEPTH   = 8,
  parameter int                 NUM_PAIRS    = 4,
  parameter int                 CMP_W        = 8,
  parameter int                 FULL_IN_N    = 3,
  parameter logic [FULL_IN_N-1:0] FULL_IN_USED = 3'b011,
  parameter int                 FREE_W       = 16,
  localparam int N  = NUM_QUAD * QUAD_DEPTH,
  localparam int AW = $clog2(N),
  localparam int PW = $clog2(NUM_PAIRS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_QUAD-1:0]  quad_wide,
  input  logic                 wr_valid,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 wr_occ,
  input  logic                 cmp_we,
  input  logic                 cmp_half,
  input  logic [PW-1:0]        cmp_pair,
  input  logic [CMP_W-1:0]     cmp_data,
  input  logic                 learn_req,
  input  logic [PW-1:0]        learn_pair,
  input  logic [FULL_IN_N-1:0] full_in,
  output logic [FREE_W-1:0]    free_addr,
  output logic                 local_full,
  output logic                 dev_full,
  output logic                 pair_err,
  output logic                 learn_we,
  output logic [FREE_W-1:0]    learn_addr,
  output logic [CMP_W-1:0]     learn_lo,
  output logic [CMP_W-1:0]     learn_hi
);
  logic [N-1:0]        occ_d;
  logic                err_q;
  logic                found;
  logic [AW-1:0]       hit_idx;
  logic [CMP_W-1:0]    bank_even, bank_odd;
  logic                learn_fire, upd;

  logic [FREE_W-1:0]   free_q, free_d;
  logic                full_q, full_d;
  logic                lwe_q, lwe_d;
  logic [FREE_W-1:0]   laddr_q, laddr_d;
  logic [CMP_W-1:0]    llo_q, llo_d, lhi_q, lhi_d;
  logic [FULL_IN_N-1:0] fin_eff;

  assign learn_fire = learn_req & ~wr_valid & ~full_q;
  assign upd        = wr_valid | learn_fire;

  nfa_occ_store #(.NUM_QUAD(NUM_QUAD), .QUAD_DEPTH(QUAD_DEPTH)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .quad_wide(quad_wide),
    .wr_en    (wr_valid),
    .wr_addr  (wr_addr),
    .wr_occ   (wr_occ),
    .lrn_en   (learn_fire),
    .lrn_addr (free_q[AW-1:0]),
    .occ_d    (occ_d),
    .err_q    (err_q)
  );

  nfa_free_finder #(.NUM_QUAD(NUM_QUAD), .QUAD_DEPTH(QUAD_DEPTH)) u_find (
    .occ      (occ_d),
    .quad_wide(quad_wide),
    .found    (found),
    .idx      (hit_idx)
  );

  nfa_cmp_bank #(.NUM_PAIRS(NUM_PAIRS), .CMP_W(CMP_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cmp_we),
    .half    (cmp_half),
    .wr_pair (cmp_pair),
    .wr_data (cmp_data),
    .rd_pair (learn_pair),
    .rd_even (bank_even),
    .rd_odd  (bank_odd)
  );

  always_comb begin
    free_d  = free_q;
    full_d  = full_q;
    if (upd) begin
      full_d = ~found;
      if (found) free_d = {{(FREE_W-AW){1'b0}}, hit_idx};
    end
    lwe_d   = learn_fire;
    laddr_d = laddr_q;
    llo_d   = llo_q;
    lhi_d   = lhi_q;
    if (learn_fire) begin
      laddr_d = free_q;
      llo_d   = bank_even;
      lhi_d   = bank_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= '0;
      full_q  <= 1'b0;
      lwe_q   <= 1'b0;
      laddr_q <= '0;
      llo_q   <= '0;
      lhi_q   <= '0;
    end else begin
      if (upd) begin
        free_q <= free_d;
        full_q <= full_d;
      end
      lwe_q <= lwe_d;
      if (learn_fire) begin
        laddr_q <= laddr_d;
        llo_q   <= llo_d;
        lhi_q   <= lhi_d;
      end
    end
  end

  assign fin_eff    = full_in | ~FULL_IN_USED;
  assign dev_full   = full_q & (&fin_eff);
  assign free_addr  = free_q;
  assign local_full = full_q;
  assign pair_err   = err_q;
  assign learn_we   = lwe_q;
  assign learn_addr = laddr_q;
  assign learn_lo   = llo_q;
  assign learn_hi   = lhi_q;
endmodule

// File: rtl/nfa_tracker_chk.sv
module nfa_tracker_chk #(
  parameter int NUM_QUAD   = 4,
  parameter int QUAD_DEPTH = 8,
  parameter int FREE_W     = 16,
  localparam int N     = NUM_QUAD * QUAD_DEPTH,
  localparam int AW    = $clog2(N),
  localparam int QBITS = $clog2(QUAD_DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_QUAD-1:0] quad_wide,
  input logic                wr_valid,
  input logic [AW-1:0]       wr_addr,
  input logic                wr_occ,
  input logic                learn_req,
  input logic [FREE_W-1:0]   free_addr,
  input logic                local_full,
  input logic                dev_full,
  input logic                pair_err,
  input logic                learn_we,
  input logic [FREE_W-1:0]   learn_addr
);
  // R2: freeing a single-width entry makes it or a lower one the free address
  p_freed_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_valid) && !$past(wr_occ) && !$past(quad_wide[wr_addr[AW-1:QBITS]]))
    |-> (!local_full && free_addr[AW-1:0] <= $past(wr_addr)));

  // R3: in a wide quadrant the recomputed free address is even
  p_wide_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_valid) && $stable(quad_wide) && !local_full &&
     quad_wide[free_addr[AW-1:QBITS]]) |-> !free_addr[0]);

  // R4: the mismatch flag never clears without reset
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |=> pair_err);

  // R6: combined full needs the local flag
  p_dev_needs_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !local_full |-> !dev_full);

  // R8: learn targets the free address of the request cycle
  p_learn_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    learn_we |-> (learn_addr == $past(free_addr)));

  // R9: a full array refuses learns
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_req && local_full) |=> !learn_we);

  // R9: a write in the same cycle wins over a learn
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !learn_we);
endmodule

bind nfa_tracker nfa_tracker_chk #(
  .NUM_QUAD  (NUM_QUAD),
  .QUAD_DEPTH(QUAD_DEPTH),
  .FREE_W    (FREE_W)
) chk_i (.*);

// File: tb/nfa_tracker_tb_top.sv
module nfa_tracker_tb_top;
  localparam int NQ = 4;
  localparam int QD = 8;
  localparam int NE = NQ * QD;
  localparam int AW = $clog2(NE);
  localparam int NP = 4;
  localparam int PW = $clog2(NP);
  localparam int CW = 8;
  localparam int FN = 3;
  localparam logic [FN-1:0] FUSED = 3'b011;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ-1:0] quad_wide;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic wr_occ;
  logic cmp_we, cmp_half;
  logic [PW-1:0] cmp_pair;
  logic [CW-1:0] cmp_data;
  logic learn_req;
  logic [PW-1:0] learn_pair;
  logic [FN-1:0] full_in;
  logic [FW-1:0] free_addr, learn_addr;
  logic local_full, dev_full, pair_err, learn_we;
  logic [CW-1:0] learn_lo, learn_hi;

  always #10 clk = ~clk;

  nfa_tracker #(.NUM_QUAD(NQ), .QUAD_DEPTH(QD), .NUM_PAIRS(NP), .CMP_W(CW),
                .FULL_IN_N(FN), .FULL_IN_USED(FUSED), .FREE_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .quad_wide(quad_wide), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_occ(wr_occ), .cmp_we(cmp_we), .cmp_half(cmp_half),
    .cmp_pair(cmp_pair), .cmp_data(cmp_data), .learn_req(learn_req),
    .learn_pair(learn_pair), .full_in(full_in), .free_addr(free_addr),
    .local_full(local_full), .dev_full(dev_full), .pair_err(pair_err),
    .learn_we(learn_we), .learn_addr(learn_addr), .learn_lo(learn_lo),
    .learn_hi(learn_hi));

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  bit m_occ [NE];
  bit [CW-1:0] m_cmp [2*NP];
  int m_free;
  bit m_full, m_err, m_lwe;
  int m_laddr;
  bit [CW-1:0] m_llo, m_lhi;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_free();
    for (int i = 0; i < NE; i++) begin
      if (quad_wide[i / QD]) begin
        if ((i % 2 == 0) && !m_occ[i] && !m_occ[i+1]) return i;
      end else if (!m_occ[i]) return i;
    end
    return -1;
  endfunction

  function automatic int mate(input int a);
    return a ^ 1;
  endfunction

  // Reference update for one clock edge, from the inputs held across it.
  task automatic model_edge();
    bit fire;
    int f;
    fire = learn_req && !wr_valid && !m_full;
    m_lwe = fire;
    if (fire) begin
      m_laddr = m_free;
      m_llo = m_cmp[2*learn_pair];
      m_lhi = m_cmp[2*learn_pair+1];
    end
    if (cmp_we) m_cmp[2*cmp_pair + (cmp_half ? 1 : 0)] = cmp_data;
    if (wr_valid) begin
      m_occ[wr_addr] = wr_occ;
      if (quad_wide[wr_addr / QD] && (m_occ[wr_addr] != m_occ[mate(wr_addr)])) m_err = 1'b1;
    end else if (fire) begin
      m_occ[m_free] = 1'b1;
      if (quad_wide[m_free / QD]) m_occ[mate(m_free)] = 1'b1;
    end
    if (wr_valid || fire) begin
      f = find_free();
      m_full = (f < 0);
      if (f >= 0) m_free = f;
    end
  endtask

  task automatic check_all();
    bit exp_dev;
    string ftag;
    ftag = quad_wide[m_free / QD] ? "R3 free_addr" : "R2 free_addr";
    chk(ftag, free_addr, m_free);
    chk("R5 local_full", local_full, m_full);
    chk("R4 pair_err", pair_err, m_err);
    exp_dev = m_full && (&(full_in | ~FUSED));
    chk("R6 dev_full", dev_full, exp_dev);
    chk(m_full ? "R9 learn_we" : "R8 learn_we", learn_we, m_lwe);
    if (m_lwe) begin
      chk("R8 learn_addr", learn_addr, m_laddr);
      chk("R7 learn_lo", learn_lo, m_llo);
      chk("R7 learn_hi", learn_hi, m_lhi);
    end
  endtask

  task automatic idle_inputs();
    wr_valid = 1'b0; wr_addr = '0; wr_occ = 1'b0;
    cmp_we = 1'b0; cmp_half = 1'b0; cmp_pair = '0; cmp_data = '0;
    learn_req = 1'b0; learn_pair = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  task automatic do_write(input int a, input bit v);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_occ = v;
    tick();
  endtask

  task automatic do_cmp(input int p, input bit h, input int d);
    cmp_we = 1'b1; cmp_pair = PW'(p); cmp_half = h; cmp_data = CW'(d);
    tick();
  endtask

  task automatic do_learn(input int p);
    learn_req = 1'b1; learn_pair = PW'(p);
    tick();
  endtask

  initial begin
    rst_n = 1'b0;
    quad_wide = '0;
    full_in = '0;
    idle_inputs();
    for (int i = 0; i < NE; i++) m_occ[i] = 1'b0;
    for (int i = 0; i < 2*NP; i++) m_cmp[i] = '0;
    m_free = 0; m_full = 0; m_err = 0; m_lwe = 0; m_laddr = 0; m_llo = 0; m_lhi = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 free_addr", free_addr, 0);
    chk("R1 local_full", local_full, 0);
    chk("R1 dev_full", dev_full, 0);
    chk("R1 pair_err", pair_err, 0);
    chk("R1 learn_we", learn_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2/R5: fill every single-width entry in order
    for (int a = 0; a < NE; a++) do_write(a, 1'b1);
    chk("R5 full after fill", local_full, 1);
    full_in = 3'b011; @(negedge clk); check_all();
    full_in = 3'b101; @(negedge clk); check_all();
    // R9: learn while full is ignored
    do_cmp(1, 1'b0, 8'hA5);
    do_cmp(1, 1'b1, 8'h5A);
    do_learn(1);
    chk("R9 no learn when full", learn_we, 0);
    // R2 then R8: free entry 13 and learn into it
    do_write(13, 1'b0);
    chk("R2 freed slot", free_addr, 13);
    do_learn(1);
    chk("R8 learn hits slot", learn_addr, 13);
    chk("R7 even half", learn_lo, 8'hA5);
    chk("R7 odd half", learn_hi, 8'h5A);
    // R3/R4: quadrant 1 becomes wide, half-free a pair
    quad_wide = 4'b0010;
    do_write(10, 1'b0);
    chk("R4 mismatch flagged", pair_err, 1);
    chk("R4 mismatch counts occupied", local_full, 1);
    do_write(11, 1'b0);
    chk("R3 pair free at even", free_addr, 10);
    do_learn(0);
    chk("R8 wide learn addr", learn_addr, 10);
    chk("R3 pair refilled", local_full, 1);
    // R9: write and learn in one cycle, write wins
    do_write(5, 1'b0);
    wr_valid = 1'b1; wr_addr = AW'(7); wr_occ = 1'b0; learn_req = 1'b1;
    tick();
    chk("R9 write wins", learn_we, 0);
    chk("R9 free unaffected by learn", free_addr, 5);

    // Random traffic
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 63) == 0) quad_wide = NQ'($urandom);
      full_in = FN'($urandom);
      if (r < 55) begin
        wr_valid = 1'b1; wr_addr = AW'($urandom);
        wr_occ = ($urandom_range(0, 99) < 60);
        if ($urandom_range(0, 9) == 0) learn_req = 1'b1;
      end else if (r < 80) begin
        learn_req = 1'b1; learn_pair = PW'($urandom);
      end else if (r < 95) begin
        cmp_we = 1'b1; cmp_pair = PW'($urandom); cmp_half = 1'($urandom);
        cmp_data = CW'($urandom);
      end
      tick();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule